// File: doc/BRIEF.md
# Unified Add/Subtract Unit

This block is a single integer adder that produces every add and subtract variant from one datapath. Before the add, operand A can be bit-inverted. After the add, the sum can be bit-inverted. The carry-in comes from constant zero, constant one, or a carry flag held inside the block. Setting invert-A and carry-in one gives B minus A. Using the held flag as carry-in gives the extended forms that chain limbs together. Inverting A with B at zero and carry-in one gives a negate.

An operation is accepted on any clock edge where `in_valid` is high. The result, the signed overflow and the updated carry flag appear one edge later, qualified by `out_valid`. A two-state machine tracks output validity:

- `ST_IDLE` means no result is pending.
- `ST_RESULT` means a result is presented this cycle.

Transitions:

- `GO_RESULT` (`ST_IDLE` to `ST_RESULT`) is taken on an accepted operation.
- `STAY_RESULT` (`ST_RESULT` to `ST_RESULT`) is taken on back-to-back operations.
- `GO_IDLE` (`ST_RESULT` to `ST_IDLE`) is taken when `in_valid` is low.
- `STAY_IDLE` (`ST_IDLE` to `ST_IDLE`) is taken when `in_valid` stays low.

Top module: `addsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared after that edge: `out_valid`, `carry_flag`, `result` and `overflow`.
- R2: `out_valid` is high in exactly the cycle after each edge that sampled `in_valid` high, and low otherwise.
- R3: With X = (`inv_a` ? ~A : A) and S = (X + B + cin) mod 2^WIDTH, `result` equals `inv_out` ? ~S : S.
- R4: `carry_sel` encodes the carry-in as follows: 2'b00 selects 0, 2'b01 selects 1, 2'b10 selects the held `carry_flag`, and 2'b11 is reserved and treated as 0.
- R5: On an accepted operation with `write_carry` high, `carry_flag` takes the carry out of the top bit of X + B + cin, taken before any output inversion.
- R6: On an accepted operation, `overflow` is high exactly when X and B, read as signed values, plus cin fall outside the signed WIDTH-bit range.
- R7: `inv_a`=1 with `carry_sel`=2'b01 and `inv_out`=0 yields B minus A; with B=0 this is the negation of A.
- R8: `carry_flag` is unchanged by any edge where `in_valid` is low or `write_carry` is low.
- R9: `result` and `overflow` hold their last values across cycles with no accepted operation.
- R10: An operation that selects the held flag sees the value written by the preceding operation, so back-to-back operations chain carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted on this edge |
| op_a | input | WIDTH | Operand A (optionally inverted) |
| op_b | input | WIDTH | Operand B |
| carry_sel | input | 2 | Carry-in source select |
| inv_a | input | 1 | Invert operand A before the add |
| inv_out | input | 1 | Invert the sum before output |
| write_carry | input | 1 | Update the held carry flag |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | WIDTH | Registered result |
| carry_flag | output | 1 | Held carry flag |
| overflow | output | 1 | Registered signed overflow |

## Verification
The assertions assume that the control inputs and operands are stable and known at every edge where `in_valid` is high, and that reset is applied for at least one edge before the first operation. The assertions on arithmetic only relate an output to the operands one edge earlier, so they hold for any operand values. The stimulus drives all inputs on the falling edge so that every value is settled at the rising edge. It holds reset for several edges before any operation. It keeps `carry_sel` within its two-bit field, using the reserved code only where the zero carry-in behaviour is under test.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'b00,
        CIN_ONE  = 2'b01,
        CIN_FLAG = 2'b10,
        CIN_RSVD = 2'b11
    } cin_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

endpackage

// File: rtl/addsub_cond_inv.sv
module addsub_cond_inv #(
    parameter int WIDTH = 64
) (
    input  logic             flip,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    always_comb begin
        dout = din ^ (flip ? ONES : '0);
    end
endmodule

// File: rtl/addsub_cin_sel.sv
module addsub_cin_sel
    import addsub_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       held_flag,
    output logic       cin
);
    cin_sel_e sel_e;

    always_comb begin
        sel_e = cin_sel_e'(sel);
        unique case (sel_e)
            CIN_ZERO: cin = 1'b0;
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = held_flag;
            CIN_RSVD: cin = 1'b0;
            default:  cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             inv_a,
    input  logic             inv_out,
    input  logic             cin,
    output logic [WIDTH-1:0] sum_out,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH:0]   wide_sum;
    logic [WIDTH-1:0] raw_sum;

    addsub_cond_inv #(.WIDTH(WIDTH)) u_inv_a (
        .flip (inv_a),
        .din  (a),
        .dout (a_eff)
    );

    always_comb begin
        wide_sum = {1'b0, a_eff} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        raw_sum  = wide_sum[MSB:0];
        cout     = wide_sum[WIDTH];
        ovf      = (a_eff[MSB] == b[MSB]) && (raw_sum[MSB] != b[MSB]);
    end

    addsub_cond_inv #(.WIDTH(WIDTH)) u_inv_out (
        .flip (inv_out),
        .din  (raw_sum),
        .dout (sum_out)
    );
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       carry_sel,
    input  logic             inv_a,
    input  logic             inv_out,
    input  logic             write_carry,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             carry_flag,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    out_state_e       state_q, state_d;
    logic             cin;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    logic             ovf_w;

    addsub_cin_sel u_cin (
        .sel       (carry_sel),
        .held_flag (carry_flag),
        .cin       (cin)
    );

    addsub_datapath #(.WIDTH(WIDTH)) u_dp (
        .a       (op_a),
        .b       (op_b),
        .inv_a   (inv_a),
        .inv_out (inv_out),
        .cin     (cin),
        .sum_out (sum_w),
        .cout    (cout_w),
        .ovf     (ovf_w)
    );

    // Next-state logic: GO_RESULT, STAY_RESULT, GO_IDLE, STAY_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            overflow   <= 1'b0;
            carry_flag <= 1'b0;
        end else if (in_valid) begin
            result   <= sum_w;
            overflow <= ovf_w;
            if (write_carry) carry_flag <= cout_w;
        end
    end

    always_comb out_valid = (state_q == ST_RESULT);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && write_carry) |=> $stable(carry_flag));
    assert_plain_add_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !inv_a && !inv_out && carry_sel == 2'b00)
        |=> result == $past(op_a) + $past(op_b));
    assert_subtract_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && inv_a && !inv_out && carry_sel == 2'b01)
        |=> result == $past(op_b) - $past(op_a));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !inv_a && (op_a[MSB] != op_b[MSB])) |=> !overflow);
endmodule

// File: tb/addsub_unit_tb.sv
`timescale 1ns/1ps
module addsub_unit_tb_top;
    localparam int W = 64;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MPOS = {1'b0, {(W-1){1'b1}}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [1:0] carry_sel = 2'b00;
    logic inv_a = 1'b0, inv_out = 1'b0, write_carry = 1'b0;
    logic out_valid, carry_flag, overflow;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addsub_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .carry_sel(carry_sel), .inv_a(inv_a), .inv_out(inv_out),
        .write_carry(write_carry), .out_valid(out_valid), .result(result),
        .carry_flag(carry_flag), .overflow(overflow)
    );

    // Behavioural reference model
    logic         m_valid = 1'b0, m_carry = 1'b0, m_ovf = 1'b0;
    logic [W-1:0] m_res = '0;
    string        m_tag = "R1";
    bit           m_live = 1'b0;

    task automatic check1(input string tag, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [W-1:0] x;
        logic [W:0] full;
        logic cin;
        longint unsigned dummy;
        logic signed [W+1:0] ssum;
        dummy = 0;
        if (rst) begin
            m_valid = 0; m_carry = 0; m_ovf = 0; m_res = '0; m_tag = "R1";
            m_live = 1;
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                x = inv_a ? ~op_a : op_a;
                // R4: 00 -> 0, 01 -> 1, 10 -> flag, 11 -> 0
                case (carry_sel)
                    2'b01: cin = 1'b1;
                    2'b10: cin = m_carry;
                    default: cin = 1'b0;
                endcase
                full = {1'b0, x} + {1'b0, op_b} + (W+1)'(cin);
                ssum = (W+2)'($signed(x)) + (W+2)'($signed(op_b)) + (W+2)'(cin);
                m_ovf = (ssum > (W+2)'($signed({1'b0, MPOS}))) ||
                        (ssum < -(W+2)'($signed({1'b0, MNEG})));
                m_res = inv_out ? ~full[W-1:0] : full[W-1:0];
                if (write_carry) m_carry = full[W];
                m_tag = cur_tag;
            end else begin
                m_tag = "R9";
            end
        end
        #1;
        if (m_live && !done) begin
            check1("R2", "out_valid", W'(out_valid), W'(m_valid));
            check1(m_tag, "result", result, m_res);
            check1("R5", "carry_flag", W'(carry_flag), W'(m_carry));
            check1("R6", "overflow", W'(overflow), W'(m_ovf));
        end
    end

    task automatic op(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [1:0] s, input logic ia, input logic io,
                      input logic wc, input string tag);
        @(negedge clk);
        in_valid = 1; op_a = a; op_b = b; carry_sel = s;
        inv_a = ia; inv_out = io; write_carry = wc; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; op_a = ~op_a; op_b = ~op_b; write_carry = 1;
        end
    endtask

    initial begin
        #50000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R3 plain add, R6 overflow at max positive
        op(64'd5, 64'd7, 2'b00, 0, 0, 1, "R3");
        op(MPOS, 64'd1, 2'b00, 0, 0, 1, "R6");
        // R5 carry out from all-ones plus one
        op(ONES, 64'd1, 2'b00, 0, 0, 1, "R5");
        // R10 chain: flag=1 consumed by next op
        op(64'd10, 64'd20, 2'b10, 0, 0, 1, "R10");
        // R7 subtract and negate
        op(64'd3, 64'd100, 2'b01, 1, 0, 1, "R7");
        op(64'd1, 64'd0, 2'b01, 1, 0, 0, "R7");
        op(MNEG, 64'd0, 2'b01, 1, 0, 0, "R7");
        // extended subtract using held flag
        op(64'd9, 64'd4, 2'b10, 1, 0, 1, "R4");
        op(64'd1, 64'd1, 2'b10, 1, 0, 1, "R4");
        // R4 reserved code acts as zero
        op(64'd1, 64'd2, 2'b11, 0, 0, 1, "R4");
        op(MNEG, MNEG, 2'b00, 0, 0, 1, "R6");
        // R8 flag untouched when write_carry low
        op(ONES, ONES, 2'b01, 0, 0, 0, "R8");
        op(64'd0, 64'd0, 2'b10, 0, 0, 0, "R8");
        // R3 output inversion
        op(64'h1234, 64'h1, 2'b00, 0, 1, 1, "R3");
        idle(4);  // R9 hold, R8 with in_valid low
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 7 == 0) ra = ONES;
            if (i % 11 == 0) rb = MNEG;
            op(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R3");
            if (i % 13 == 0) idle(2);
        end
        idle(2);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; // R1 checked by model during reset
        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule